// File: doc/BRIEF.md
# ADC Conversion Sequencer with Result Justification

This block is the digital control half of a successive-approximation converter. A single 8-bit control register holds a two-bit reference choice, a left-justify flag and a five-bit channel/gain code. The block keeps a separate active copy of the reference and channel settings, which the analog side would use. That copy only follows the control register while no conversion is running, so a setting can never change halfway through a measurement.

A start pulse launches a conversion when the block is idle. A conversion lasts a fixed number of cycles: 13 in the normal case, and 25 for the first conversion after the reference choice has been changed. The analog path is not modelled. Instead, a 10-bit sample value supplied by the environment is captured in the cycle the conversion ends. The captured result is presented across two data bytes, left- or right-justified according to the current flag. A sticky completion flag reports the end of each conversion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control register reads 0, busy and done are 0, both data bytes are 0, the active reference and channel are 0, and `ref_mode` reads 0 while `ext_ref_en` is 0.
- R2: A write stores all 8 bits, readable on `cfg_rdata` from the next cycle. Bits 7:6 are the reference choice, bit 5 is the left-justify flag and bits 4:0 are the channel/gain code.
- R3: When `start` is high while busy is 0, busy is 1 from the next cycle. Busy stays high for 13 cycles, then falls. Done is set in that same cycle, and the result is `sample_val` as seen on the last busy cycle.
- R4: A `start` pulse while busy is 1 has no effect: the running conversion keeps its length and its end time.
- R5: A write whose bits 7:6 differ from the stored bits 7:6 makes the next conversion last 25 cycles. The conversion after that lasts 13 cycles. A write with unchanged bits 7:6 does not lengthen anything.
- R6: A write during a conversion leaves `act_ref` and `act_chan` unchanged until busy has fallen. They take the new values one cycle after busy falls.
- R7: A write while idle updates `act_ref` and `act_chan` in the cycle after the write.
- R8: The 16-bit word {`data_hi`,`data_lo`} is the result shifted left by 6 when bit 5 is 1, and the zero-extended result when bit 5 is 0. A change of bit 5 shows on the data bytes in the cycle after the write, even during a conversion.
- R9: Done stays 1 until a cycle with `done_clr` high clears it. If a conversion ends in the same cycle as `done_clr`, done stays 1.
- R10: `ref_mode` decodes the active reference choice as follows:
  - 00 gives 1 (external pin) when `ext_ref_en` is 1, and 0 (off) when it is 0.
  - 01 gives 2 (supply).
  - 10 gives 3 (internal 1.1 V).
  - 11 gives 4 (internal 2.56 V).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| ext_ref_en | input | 1 | External reference enable, used with reference choice 00 |
| start | input | 1 | Conversion start request |
| sample_val | input | 10 | Sampled analog value, captured at conversion end |
| done_clr | input | 1 | Write-one-to-clear for done |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Sticky completion flag |
| act_ref | output | 2 | Active reference choice |
| act_chan | output | 5 | Active channel/gain code |
| ref_mode | output | 3 | Decoded reference source |
| data_hi | output | 8 | Upper result byte |
| data_lo | output | 8 | Lower result byte |

## Verification
The assertions check the following on every cycle:
- a start from idle raises busy;
- every busy run lasts exactly 13 or 25 cycles and ends with done set;
- the active settings never move while a conversion runs;
- done holds until it is cleared;
- the padding bits of the data word are zero for the current justification;
- the reference decode stays in its legal range.

Only the bench scenarios can show which length each conversion gets: long after a real reference change, short after a write with the same reference. They also show that a second start is ignored, that the captured value and its layout are correct, that a mid-conversion flip of the justify flag is visible at once, and the exact cycle in which held-back settings are applied.

// File: rtl/adc_seq_pkg.sv
// Package: shared field layout and reference decode for the ADC sequencer.
// Assumes an 8-bit control register with fixed field positions.
package adc_seq_pkg;
    localparam int CFG_W   = 8;
    localparam int REF_W   = 2;
    localparam int CHAN_W  = 5;
    localparam int REF_MSB = 7;
    localparam int REF_LSB = 6;
    localparam int LJ_BIT  = 5;

    typedef enum logic [2:0] {
        REF_OFF    = 3'd0,
        REF_PIN    = 3'd1,
        REF_SUPPLY = 3'd2,
        REF_BG1V1  = 3'd3,
        REF_BG2V56 = 3'd4
    } ref_mode_e;

    // Map the reference choice plus external enable to a source.
    function automatic ref_mode_e ref_decode(input logic [REF_W-1:0] sel, input logic ext_en);
        case (sel)
            2'b00:   ref_decode = ext_en ? REF_PIN : REF_OFF;
            2'b01:   ref_decode = REF_SUPPLY;
            2'b10:   ref_decode = REF_BG1V1;
            default: ref_decode = REF_BG2V56;
        endcase
    endfunction
endpackage

// File: rtl/adc_cfg_regs.sv
// Control register, active setting copy and pending-reference tracking.
// Assumes: the active copy may follow the register only while not busy;
// a launch consumes any pending reference change.
module adc_cfg_regs
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_W-1:0]  wdata,
    input  logic              busy,
    input  logic              launch,
    output logic [CFG_W-1:0]  reg_q,
    output logic [REF_W-1:0]  act_ref,
    output logic [CHAN_W-1:0] act_chan,
    output logic              long_req
);
    logic             pend_q;
    logic             ref_chg;
    logic [CFG_W-1:0] reg_nxt;

    // Next register value and detection of a real reference change.
    always_comb begin
        reg_nxt  = we ? wdata : reg_q;
        ref_chg  = we && (wdata[REF_MSB:REF_LSB] != reg_q[REF_MSB:REF_LSB]);
        long_req = pend_q || ref_chg;
    end

    // Control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_nxt;
    end

    // Active copy follows the register only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_ref  <= '0;
            act_chan <= '0;
        end else if (!busy) begin
            act_ref  <= reg_nxt[REF_MSB:REF_LSB];
            act_chan <= reg_nxt[CHAN_W-1:0];
        end
    end

    // Pending flag: set by a reference change, consumed at launch.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (launch) pend_q <= 1'b0;
        else if (ref_chg) pend_q <= 1'b1;
    end
endmodule

// File: rtl/adc_conv_timer.sv
// Conversion timer: busy window of SHORT_CYC or LONG_CYC cycles, result
// capture on the last cycle, sticky done flag.
// Assumes: start is honoured only while idle; a set beats a clear.
module adc_conv_timer #(
    parameter int RES_W     = 10,
    parameter int SHORT_CYC = 13,
    parameter int LONG_CYC  = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             long_req,
    input  logic [RES_W-1:0] sample_val,
    input  logic             done_clr,
    output logic             busy,
    output logic             done,
    output logic             launch,
    output logic [RES_W-1:0] result
);
    localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             finish;

    // Launch and finish strobes.
    always_comb begin
        launch = start && !busy;
        finish = busy && (cnt_q == '0);
    end

    // Busy window and down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (launch) begin
            busy  <= 1'b1;
            cnt_q <= long_req ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
        end else if (finish) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Result capture at the end of a conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)      result <= '0;
        else if (finish) result <= sample_val;
    end

    // Sticky done flag; completion wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        done <= 1'b0;
        else if (finish)   done <= 1'b1;
        else if (done_clr) done <= 1'b0;
    end
endmodule

// File: rtl/adc_result_align.sv
// Result justification across a data word of two bytes.
// Assumes: the justify flag acts combinationally on the stored result.
module adc_result_align #(
    parameter int RES_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic              left_adj,
    input  logic [RES_W-1:0]  result,
    output logic [DATA_W-1:0] word
);
    localparam int PAD_W = DATA_W - RES_W;

    // Place the result at the top or bottom of the word.
    always_comb begin
        if (left_adj) word = {result, {PAD_W{1'b0}}};
        else          word = {{PAD_W{1'b0}}, result};
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top: ADC conversion sequencer with settings held back during conversions
// and an immediately reacting result justification.
// Assumes: a single clock, synchronous active-low reset.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int SHORT_CYC = 13,
    parameter int LONG_CYC  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              ext_ref_en,
    input  logic              start,
    input  logic [RES_W-1:0]  sample_val,
    input  logic              done_clr,
    output logic              busy,
    output logic              done,
    output logic [1:0]        act_ref,
    output logic [4:0]        act_chan,
    output logic [2:0]        ref_mode,
    output logic [7:0]        data_hi,
    output logic [7:0]        data_lo
);
    localparam int BYTE_W = 8;
    localparam int DATA_W = 2 * BYTE_W;

    logic              launch;
    logic              long_req;
    logic [RES_W-1:0]  result;
    logic [DATA_W-1:0] word;

    adc_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .busy     (busy),
        .launch   (launch),
        .reg_q    (cfg_rdata),
        .act_ref  (act_ref),
        .act_chan (act_chan),
        .long_req (long_req)
    );

    adc_conv_timer #(
        .RES_W     (RES_W),
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .long_req   (long_req),
        .sample_val (sample_val),
        .done_clr   (done_clr),
        .busy       (busy),
        .done       (done),
        .launch     (launch),
        .result     (result)
    );

    adc_result_align #(
        .RES_W  (RES_W),
        .DATA_W (DATA_W)
    ) u_align (
        .left_adj (cfg_rdata[LJ_BIT]),
        .result   (result),
        .word     (word)
    );

    // Split the word into bytes and decode the active reference.
    always_comb begin
        data_hi  = word[DATA_W-1:BYTE_W];
        data_lo  = word[BYTE_W-1:0];
        ref_mode = ref_decode(act_ref, ext_ref_en);
    end
endmodule

// File: rtl/adc_seq_chk.sv
// Checker: cycle-by-cycle properties of the ADC sequencer ports.
// Assumes: bound to adc_seq_ctrl with its default field layout.
module adc_seq_chk #(
    parameter int RES_W     = 10,
    parameter int SHORT_CYC = 13,
    parameter int LONG_CYC  = 25
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       done_clr,
    input logic       busy,
    input logic       done,
    input logic [7:0] cfg_rdata,
    input logic [1:0] act_ref,
    input logic [4:0] act_chan,
    input logic [2:0] ref_mode,
    input logic [7:0] data_hi,
    input logic [7:0] data_lo
);
    localparam int PAD_W = 16 - RES_W;

    logic [7:0]  run_cnt;
    logic [15:0] word;

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run_cnt <= '0;
        else if (run_cnt != 8'hFF) run_cnt <= run_cnt + 1'b1;
    end

    // Combined data word.
    always_comb word = {data_hi, data_lo};

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R3
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == 8'(SHORT_CYC) || run_cnt == 8'(LONG_CYC)));
    // R3
    fell_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R6
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> ($stable(act_ref) && $stable(act_chan)));
    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr) |=> done);
    // R8
    left_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[5] |-> (word[PAD_W-1:0] == '0));
    // R8
    right_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[5] |-> ((word >> RES_W) == '0));
    // R10
    ref_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_mode <= 3'd4);
endmodule

bind adc_seq_ctrl adc_seq_chk #(
    .RES_W     (RES_W),
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done_clr  (done_clr),
    .busy      (busy),
    .done      (done),
    .cfg_rdata (cfg_rdata),
    .act_ref   (act_ref),
    .act_chan  (act_chan),
    .ref_mode  (ref_mode),
    .data_hi   (data_hi),
    .data_lo   (data_lo)
);

// File: tb/tb_adc_seq_ctrl.sv
// Scoreboard bench: the driver queues expected conversions, the monitor
// pops one each time busy falls and compares length, done and data.
module tb_adc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       ext_ref_en = 1'b0;
    logic       start = 1'b0;
    logic [9:0] sample_val = '0;
    logic       done_clr = 1'b0;
    logic       busy, done;
    logic [1:0] act_ref;
    logic [4:0] act_chan;
    logic [2:0] ref_mode;
    logic [7:0] data_hi, data_lo;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        int         len;
        logic [7:0] hi;
        logic [7:0] lo;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ext_ref_en(ext_ref_en), .start(start),
        .sample_val(sample_val), .done_clr(done_clr), .busy(busy), .done(done),
        .act_ref(act_ref), .act_chan(act_chan), .ref_mode(ref_mode),
        .data_hi(data_hi), .data_lo(data_lo)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // Push the expected item and launch one conversion.
    task automatic conv_start(input logic [9:0] sv, input int len, input logic left, input string tag);
        exp_t e;
        logic [15:0] w;
        w = left ? {sv, 6'b0} : {6'b0, sv};
        e.len = len; e.hi = w[15:8]; e.lo = w[7:0]; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk); start = 1'b1; sample_val = sv;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R3 busy after start", int'(busy), 1);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic clear_done();
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
        chk(done == 1'b0, "R9 done cleared", int'(done), 0);
    endtask

    // Monitor: measure each busy run and compare against the queue.
    int  run = 0;
    logic prev_busy = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_busy && !busy) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected conversion", run, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(run == e.len, {e.tag, " length"}, run, e.len);
                    chk(done == 1'b1, "R3 done at end", int'(done), 1);
                    chk(data_hi == e.hi, {"R8 ", e.tag, " data_hi"}, int'(data_hi), int'(e.hi));
                    chk(data_lo == e.lo, {"R8 ", e.tag, " data_lo"}, int'(data_lo), int'(e.lo));
                end
                run = 0;
            end
            if (busy) run++;
            prev_busy = busy;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cfg_rdata == 8'h00, "R1 cfg_rdata", int'(cfg_rdata), 0);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", int'({busy, done}), 0);
        chk({data_hi, data_lo} == 16'h0, "R1 data", int'({data_hi, data_lo}), 0);
        chk(act_ref == 2'd0 && act_chan == 5'd0, "R1 active", int'({act_ref, act_chan}), 0);
        chk(ref_mode == 3'd0, "R1 ref_mode", int'(ref_mode), 0);

        // R2 / R7 / R10: idle write, reference 10, left, channel 22
        wr(8'b10_1_10110);
        chk(cfg_rdata == 8'hB6, "R2 readback", int'(cfg_rdata), 'hB6);
        chk(act_ref == 2'd2 && act_chan == 5'd22, "R7 idle apply", int'({act_ref, act_chan}), 'h56);
        chk(ref_mode == 3'd3, "R10 1.1V", int'(ref_mode), 3);

        // R5: first conversion after the reference change is long
        conv_start(10'h2A5, 25, 1'b1, "R5 long");
        wait_idle();
        conv_start(10'h3FF, 13, 1'b1, "R5 short");
        wait_idle();
        @(negedge clk);
        chk(done == 1'b1, "R9 sticky", int'(done), 1);
        clear_done();

        // R8: right-justify while idle, same reference (no lengthening)
        wr(8'b10_0_10110);
        chk(data_hi == 8'h03 && data_lo == 8'hFF, "R8 right idle", int'({data_hi, data_lo}), 'h03FF);

        // R4: second start mid-conversion is ignored
        conv_start(10'h155, 13, 1'b0, "R4 restart ignored");
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_idle();

        // R6 / R8: writes during a conversion
        conv_start(10'h0F0, 13, 1'b1, "R8 flip mid");
        repeat (2) @(negedge clk);
        wr(8'b01_0_00011);
        chk(act_ref == 2'd2 && act_chan == 5'd22, "R6 held while busy", int'({act_ref, act_chan}), 'h56);
        chk(cfg_rdata == 8'h43, "R2 readback busy", int'(cfg_rdata), 'h43);
        wr(8'b01_1_00011);
        chk(busy == 1'b1, "R8 still busy", int'(busy), 1);
        chk(data_hi == 8'h55 && data_lo == 8'h40, "R8 immediate left", int'({data_hi, data_lo}), 'h5540);
        wait_idle();
        @(negedge clk);
        chk(act_ref == 2'd1 && act_chan == 5'd3, "R6 applied after end", int'({act_ref, act_chan}), 'h23);
        chk(ref_mode == 3'd2, "R10 supply", int'(ref_mode), 2);

        // R5 / R9: long conversion (pending from mid write) ending under a held clear
        done_clr = 1'b1;
        conv_start(10'h001, 25, 1'b1, "R5 pending kept");
        wait_idle();
        chk(done == 1'b1, "R9 set beats clear", int'(done), 1);
        @(negedge clk); done_clr = 1'b0;
        clear_done();

        // R10: reference 00 with and without external enable
        wr(8'b00_0_00000);
        ext_ref_en = 1'b1;
        @(negedge clk);
        chk(ref_mode == 3'd1, "R10 pin", int'(ref_mode), 1);
        ext_ref_en = 1'b0;
        @(negedge clk);
        chk(ref_mode == 3'd0, "R10 off", int'(ref_mode), 0);

        conv_start(10'h200, 25, 1'b0, "R5 long again");
        wait_idle();
        @(negedge clk);
        chk(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule